// File: doc/BRIEF.md
# Sectioned Register-File Access Controller

This block holds a small byte-addressed register file that is split into fixed sections: two alarm banks, a control bank, a clock bank and a single status byte. A bus front end, which is not part of this block, turns serial traffic into one-cycle strobes: transaction start (with a read/write flag), address, data byte, read request and stop. Only one strobe is active per cycle. If more than one is raised, the order of precedence is start, stop, address, data byte, read request. Bytes that arrive in a write transaction go into a holding buffer. The target registers change only when the transaction ends with a stop and the commit gate is open. A commit raises a one-cycle strobe that carries the section, the first address written and the byte count.

The clock counter lives outside the block. It presents its eight bytes on a parallel time bus. A read transaction start copies that bus into a snapshot, so a tick during a burst never mixes old and new time. A committed clock write is handed back to the counter as a byte-masked load. The address pointer survives between transactions. A read start with no address therefore continues where the previous access stopped, and bursts wrap inside the section they started in.

Section map (address, section code): 0x00–0x07 alarm-0 (0), 0x08–0x0F alarm-1 (1), 0x10–0x13 control (2), 0x30–0x37 clock (3), 0x3F status (4). Every other address is undefined.

Top module: `sect_regfile`

## Requirements
- R1: After reset, no read data or commit is signalled, the pointer is 0x00, and all stored alarm, control and status-enable bytes are zero.
- R2: Written bytes have no effect before stop. A stop that ends a write transaction whose gate is open raises commit_o for exactly one cycle, in the cycle after the stop, carrying section code, first address and byte count.
- R3: Writes to the alarm, control and clock sections commit only if the register-write-enable bit (status bit 2) is 1 when the stop arrives. Otherwise the stop commits nothing.
- R4: A burst read or write that reaches the end of its section continues at the first address of that same section.
- R5: A burst may begin at any address inside a section. The commit reports that address as its first address.
- R6: The status byte at 0x3F may be written without the enable bit. Only bits 2 (write-enable) and 1 (write-latch) are stored. A read returns {stat_i[3], stat_i[2], stat_i[1], 0, 0, bit2, bit1, stat_i[0]}, from bit 7 down to bit 0.
- R7: The status section takes a single byte. A second data byte or read request ends the transaction: no read data is returned for it, the buffered byte is discarded, and no commit follows.
- R8: Starting a read transaction copies the time bus into a snapshot. Clock-section reads in that transaction return the snapshot even if the time bus changes.
- R9: After each read or write byte, the pointer moves to the next address, wrapping within the section. A read start without an address continues from there.
- R10: Reads of undefined addresses return 0x00. Writes to them are ignored and give no commit.
- R11: A start that arrives during a write transaction discards the buffered bytes. Nothing from the aborted transaction is committed.
- R12: A committed clock write drives clk_wmask_o with one bit per written clock byte (bit k for address 0x30+k) and clk_wdata_o byte k with that byte, for the commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start strobe |
| rd_i | input | 1 | With start_i: 1 = read transaction, 0 = write transaction |
| addr_vld_i | input | 1 | Address strobe (write transaction only) |
| addr_i | input | AW | Register address |
| wr_vld_i | input | 1 | Data byte strobe (write transaction) |
| wr_data_i | input | 8 | Data byte |
| rd_req_i | input | 1 | Read byte request (read transaction) |
| stop_i | input | 1 | Transaction stop strobe |
| time_i | input | 64 | Live clock bytes, byte k for address 0x30+k |
| stat_i | input | 4 | Status flags {battery, alarm1, alarm0, clock-fail} |
| rd_vld_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 8 | Read data |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_sec_o | output | 3 | Section code of the commit |
| commit_addr_o | output | AW | First address written |
| commit_cnt_o | output | CW | Bytes accepted (saturating) |
| clk_wdata_o | output | 64 | Clock load bytes |
| clk_wmask_o | output | 8 | Clock load byte mask, valid with commit_o |

## Verification
The bench builds the block with the defaults AW = 8 and CW = 4. An 8-bit address reaches every section as well as the undefined gaps between and above them. A 4-bit count can report a full eight-byte page write without saturating. That setting lets a complete alarm-bank burst wrap all the way around and be checked both through the commit count and by reading the bytes back.

// File: rtl/sect_regfile.sv
module sect_regfile #(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic          addr_vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_vld_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_req_i,
  input  logic          stop_i,
  input  logic [63:0]   time_i,
  input  logic [3:0]    stat_i,
  output logic          rd_vld_o,
  output logic [7:0]    rd_data_o,
  output logic          commit_o,
  output logic [2:0]    commit_sec_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [CW-1:0] commit_cnt_o,
  output logic [63:0]   clk_wdata_o,
  output logic [7:0]    clk_wmask_o
);

  localparam int NB = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD, ST_DEAD} state_t;
  typedef enum logic [2:0] {
    S_A0 = 3'd0, S_A1 = 3'd1, S_CTL = 3'd2, S_CLK = 3'd3, S_STS = 3'd4, S_NONE = 3'd7
  } sec_t;

  function automatic sec_t sec_of(input logic [AW-1:0] a);
    if (a[AW-1:6] != '0) return S_NONE;
    case (a[5:3])
      3'd0:    return S_A0;
      3'd1:    return S_A1;
      3'd2:    return a[2] ? S_NONE : S_CTL;
      3'd6:    return S_CLK;
      3'd7:    return (a[2:0] == 3'd7) ? S_STS : S_NONE;
      default: return S_NONE;
    endcase
  endfunction

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] a);
    case (sec_of(a))
      S_A0, S_A1, S_CLK: return {a[AW-1:3], a[2:0] + 3'd1};
      S_CTL:             return {a[AW-1:2], a[1:0] + 2'd1};
      S_STS:             return a;
      default:           return a + 1'b1;
    endcase
  endfunction

  state_t        state;
  logic [AW-1:0] ptr, wfirst;
  logic [CW-1:0] cnt;
  logic [7:0]    al0 [NB];
  logic [7:0]    al1 [NB];
  logic [7:0]    ctl [4];
  logic [7:0]    wbuf [NB];
  logic [NB-1:0] wmask;
  logic [63:0]   snap;
  logic          rwel, wel;
  logic [7:0]    rbyte;

  sec_t psec, wsec;
  assign psec = sec_of(ptr);
  assign wsec = sec_of(wfirst);

  wire gate_open = (cnt != '0) && (wsec == S_STS || rwel);
  wire do_commit = (state == ST_WR) && stop_i && !start_i && gate_open;
  wire cnt_max   = (cnt == {CW{1'b1}});

  always_comb begin
    case (psec)
      S_A0:    rbyte = al0[ptr[2:0]];
      S_A1:    rbyte = al1[ptr[2:0]];
      S_CTL:   rbyte = ctl[ptr[1:0]];
      S_CLK:   rbyte = snap[{ptr[2:0], 3'b000} +: 8];
      S_STS:   rbyte = {stat_i[3], stat_i[2], stat_i[1], 2'b00, rwel, wel, stat_i[0]};
      default: rbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr <= '0;
      wfirst <= '0;
      cnt <= '0;
      wmask <= '0;
      snap <= '0;
      rd_vld_o <= 1'b0;
      rd_data_o <= '0;
      for (int i = 0; i < NB; i++) begin
        wbuf[i] <= '0;
        al0[i] <= '0;
        al1[i] <= '0;
      end
      for (int i = 0; i < 4; i++) ctl[i] <= '0;
    end else begin
      rd_vld_o <= 1'b0;
      if (start_i) begin
        state <= rd_i ? ST_RD : ST_WR;
        cnt <= '0;
        wmask <= '0;
        if (rd_i) snap <= time_i;
      end else if (stop_i) begin
        state <= ST_IDLE;
        cnt <= '0;
        wmask <= '0;
        if (do_commit) begin
          for (int i = 0; i < NB; i++) begin
            if (wmask[i] && wsec == S_A0) al0[i] <= wbuf[i];
            if (wmask[i] && wsec == S_A1) al1[i] <= wbuf[i];
          end
          for (int i = 0; i < 4; i++)
            if (wmask[i] && wsec == S_CTL) ctl[i] <= wbuf[i];
        end
      end else if (state == ST_WR && addr_vld_i) begin
        ptr <= addr_i;
      end else if (state == ST_WR && wr_vld_i) begin
        ptr <= next_ptr(ptr);
        if (psec == S_STS && cnt != '0) begin
          state <= ST_DEAD;
          cnt <= '0;
          wmask <= '0;
        end else if (psec != S_NONE) begin
          wbuf[ptr[2:0]] <= wr_data_i;
          wmask[ptr[2:0]] <= 1'b1;
          if (cnt == '0) wfirst <= ptr;
          if (!cnt_max) cnt <= cnt + 1'b1;
        end
      end else if (state == ST_RD && rd_req_i) begin
        if (psec == S_STS && cnt != '0) begin
          state <= ST_DEAD;
        end else begin
          rd_vld_o <= 1'b1;
          rd_data_o <= rbyte;
          ptr <= next_ptr(ptr);
          if (!cnt_max) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwel <= 1'b0;
      wel <= 1'b0;
    end else if (do_commit && wsec == S_STS) begin
      rwel <= wbuf[7][2];
      wel <= wbuf[7][1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o <= 1'b0;
      commit_sec_o <= '0;
      commit_addr_o <= '0;
      commit_cnt_o <= '0;
      clk_wdata_o <= '0;
      clk_wmask_o <= '0;
    end else begin
      commit_o <= do_commit;
      clk_wmask_o <= '0;
      if (do_commit) begin
        commit_sec_o <= wsec;
        commit_addr_o <= wfirst;
        commit_cnt_o <= cnt;
        if (wsec == S_CLK) clk_wmask_o <= wmask;
        for (int i = 0; i < NB; i++) clk_wdata_o[8*i +: 8] <= wbuf[i];
      end
    end
  end

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R2
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_i)); // R2
  AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && commit_sec_o != S_STS) |-> $past(rwel)); // R3
  AST_BURST_IN_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && rd_req_i && !start_i && psec != S_NONE) |=> (psec == $past(psec))); // R4
  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld_o && $past(psec) == S_NONE) |-> (rd_data_o == 8'h00)); // R10
  AST_DEAD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAD) |-> !commit_o); // R7
  AST_CLK_MASK_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_wmask_o != '0) |-> (commit_o && commit_sec_o == S_CLK)); // R12

endmodule

// File: tb/sect_regfile_test.sv
module sect_regfile_test;
  localparam int AW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 0, rd_i = 0, addr_vld_i = 0, wr_vld_i = 0, rd_req_i = 0, stop_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic [63:0]   time_i = '0;
  logic [3:0]    stat_i = '0;
  logic          rd_vld_o, commit_o;
  logic [7:0]    rd_data_o;
  logic [2:0]    commit_sec_o;
  logic [AW-1:0] commit_addr_o;
  logic [CW-1:0] commit_cnt_o;
  logic [63:0]   clk_wdata_o;
  logic [7:0]    clk_wmask_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  sect_regfile #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .wr_vld_i(wr_vld_i), .wr_data_i(wr_data_i),
    .rd_req_i(rd_req_i), .stop_i(stop_i), .time_i(time_i), .stat_i(stat_i),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .commit_o(commit_o),
    .commit_sec_o(commit_sec_o), .commit_addr_o(commit_addr_o), .commit_cnt_o(commit_cnt_o),
    .clk_wdata_o(clk_wdata_o), .clk_wmask_o(clk_wmask_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_vld_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7: actual unexpected byte %0h expected no read data", rd_data_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data_o !== e) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", t, rd_data_o, e);
        end
      end
    end
  end

  task automatic t_start(input logic rd);
    @(negedge clk); start_i = 1; rd_i = rd;
    @(negedge clk); start_i = 0; rd_i = 0;
  endtask
  task automatic t_addr(input logic [7:0] a);
    @(negedge clk); addr_vld_i = 1; addr_i = a;
    @(negedge clk); addr_vld_i = 0;
  endtask
  task automatic t_wr(input logic [7:0] d);
    @(negedge clk); wr_vld_i = 1; wr_data_i = d;
    @(negedge clk); wr_vld_i = 0;
  endtask
  task automatic t_rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_req_i = 1;
    @(negedge clk); rd_req_i = 0;
  endtask
  task automatic t_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask
  task automatic t_seek_rd(input logic [7:0] a);
    t_start(0); t_addr(a); t_start(1);
  endtask
  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1: actual watchdog expired expected test completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_vld after reset", rd_vld_o, 0);
    chk("R1 commit after reset", commit_o, 0);
    t_start(1); t_rd(8'h00, "R1 pointer 0 alarm0 byte"); t_stop();

    t_start(0); t_addr(8'h08); t_wr(8'h55); t_stop();
    chk("R3 no commit without enable", commit_o, 0);
    t_seek_rd(8'h08); t_rd(8'h00, "R3 alarm1 unchanged"); t_stop();

    stat_i = 4'b1010;
    t_start(0); t_addr(8'h3F); t_wr(8'h06); t_stop();
    chk("R6 status commit", commit_o, 1);
    chk("R6 status section", commit_sec_o, 4);
    chk("R6 status addr", commit_addr_o, 8'h3F);
    chk("R6 status count", commit_cnt_o, 1);
    @(negedge clk);
    chk("R2 commit single cycle", commit_o, 0);
    t_seek_rd(8'h3F); t_rd(8'hA6, "R6 status layout"); t_stop();

    t_start(0); t_addr(8'h12); t_wr(8'h11); t_wr(8'h22); t_wr(8'h33);
    chk("R2 no commit before stop", commit_o, 0);
    t_stop();
    chk("R2 commit strobe", commit_o, 1);
    chk("R2 control section", commit_sec_o, 2);
    chk("R5 first address", commit_addr_o, 8'h12);
    chk("R2 byte count", commit_cnt_o, 3);
    t_seek_rd(8'h12); t_rd(8'h11, "R5 control 0x12"); t_rd(8'h22, "R4 control 0x13"); t_stop();
    t_start(1); t_rd(8'h33, "R9 current read wraps to 0x10"); t_rd(8'h00, "R9 control 0x11"); t_stop();

    t_start(0); t_addr(8'h03); t_wr(8'h77); t_start(0); t_stop();
    chk("R11 abort no commit", commit_o, 0);
    t_seek_rd(8'h03); t_rd(8'h00, "R11 alarm0 unchanged"); t_stop();

    time_i = 64'h1726354453627180;
    t_seek_rd(8'h30);
    time_i = 64'hFFEEDDCCBBAA9988;
    for (int k = 0; k < 8; k++) t_rd(8'(64'h1726354453627180 >> (8*k)), "R8 snapshot byte");
    t_rd(8'h80, "R4 clock read wraps");
    t_stop();

    t_start(0); t_addr(8'h36); t_wr(8'hAA); t_wr(8'hBB); t_wr(8'hCC); t_stop();
    chk("R12 clock commit", commit_o, 1);
    chk("R12 clock section", commit_sec_o, 3);
    chk("R12 clock count", commit_cnt_o, 3);
    chk("R12 clock mask", clk_wmask_o, 8'hC1);
    chk("R12 clock byte6", clk_wdata_o[55:48], 8'hAA);
    chk("R12 clock byte7", clk_wdata_o[63:56], 8'hBB);
    chk("R12 clock byte0", clk_wdata_o[7:0], 8'hCC);

    t_start(0); t_addr(8'h3F); t_wr(8'h00); t_wr(8'h00); t_stop();
    chk("R7 double status write no commit", commit_o, 0);
    t_seek_rd(8'h3F); t_rd(8'hA6, "R7 status kept");
    @(negedge clk); rd_req_i = 1;
    @(negedge clk); rd_req_i = 0;
    chk("R7 second status read gives no data", rd_vld_o, 0);
    t_stop();

    t_start(0); t_addr(8'h20); t_wr(8'h99); t_stop();
    chk("R10 undefined write no commit", commit_o, 0);
    t_seek_rd(8'h20); t_rd(8'h00, "R10 undefined 0x20"); t_stop();
    t_seek_rd(8'h3A); t_rd(8'h00, "R10 undefined 0x3A"); t_stop();

    t_start(0); t_addr(8'h0A);
    for (int k = 0; k < 8; k++) t_wr(8'hA0 + 8'(k));
    t_stop();
    chk("R4 page commit", commit_o, 1);
    chk("R4 page section", commit_sec_o, 1);
    chk("R4 page count", commit_cnt_o, 8);
    t_start(1); t_rd(8'hA0, "R9 pointer kept after write"); t_stop();
    t_seek_rd(8'h08); t_rd(8'hA6, "R4 page wrapped to 0x08"); t_stop();

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule